// File: doc/BRIEF.md
# RAM-Backed Multi-Tap Delay Line

This block is a tapped delay line for sample streams, meant to feed filter and correlation datapaths. Each sample is `W` bits wide. The line has `N` output taps spaced `M` samples apart. The samples sit in embedded RAM, addressed as a circular buffer of `M·N` words, and not in a chain of registers. The total storage is `W·M·N` bits. Each clock edge on which `shift_en` is high writes one new sample. On that edge every tap moves forward by one sample.

The logical buffer of `M·N` words is split into `N` banks of `M` words, selected by the upper part of the write position. Every tap reads the same in-bank offset, so each bank needs one write port and one read port. Each bank reads the old word before it writes, which gives the deepest tap its full delay. A rotation stage sends each bank to the tap that currently owns it. A small fill counter keeps a tap at zero until its delay line holds real samples. A setting with `W·M·N` above 4608 bits stops elaboration with an error.

Top module: `tapline_ram`

## Requirements
- R1: After an enabled shift that brings in sample s (counting from 0 after reset), tap k (1 ≤ k ≤ N) carries sample s−k·M, provided more than k·M samples have entered. Tap k occupies bits [(k−1)·W +: W] of `taps_o`.
- R2: `taps_o` changes only on the clock edge that performs an enabled shift. A clock edge with `shift_en` low leaves every tap and the write position unchanged.
- R3: Right after reset every tap reads zero. Tap k stays zero until more than k·M samples have entered since reset.
- R4: The write position wraps modulo M·N. Tap delays stay exact over hundreds of shifts that span many wraps.
- R5: Tap N delivers the sample exactly N·M shifts old, even though its RAM word is overwritten on that same shift.
- R6: A reset raised in the middle of a stream sets every tap to zero at the next edge and restarts the fill count.
- R7: Delay is counted in enabled shifts. Idle clock cycles between shifts do not change which sample a tap shows.
- R8: `rst` has priority over `shift_en`. A cycle with both high enters no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Enter `din` and advance all taps on this edge |
| din | input | W | Incoming sample |
| taps_o | output | N·W | Tap outputs; tap k in bits [(k−1)·W +: W] |

## Verification
The bench builds the block with W=8, M=3 and N=5. Neither the bank offset range nor the bank count is then a power of two, so the wrap of the in-bank offset and the modular tap-to-bank rotation both run through their non-trivial cases. The buffer is only 15 words deep, so a few hundred shifts cover many full wraps. With 5 banks, tap N reads the bank being written in every position. Gated-enable stretches and mid-stream resets with `shift_en` held high test the hold rule, the fill gating and the reset priority against a sample-history model.

// File: rtl/tapline_pkg.sv
package tapline_pkg;

  // Largest delay-line storage accepted, in bits.
  localparam int unsigned TL_MAX_STORE_BITS = 4608;

  // Bit width needed to index n distinct values, never below one.
  function automatic int unsigned tl_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bit width needed to hold the values 0..n inclusive.
  function automatic int unsigned tl_cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tapline_ptr.sv
// Circular write position, split into in-bank offset and bank number,
// plus a saturating count of samples entered since reset.
module tapline_ptr
  import tapline_pkg::*;
#(
  parameter int unsigned M = 4,
  parameter int unsigned N = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  output logic [tl_idx_width(M)-1:0]   off_o,
  output logic [tl_idx_width(N)-1:0]   seg_o,
  output logic [tl_cnt_width(M*N)-1:0] fill_o
);

  localparam int unsigned OW    = tl_idx_width(M);
  localparam int unsigned SW    = tl_idx_width(N);
  localparam int unsigned CW    = tl_cnt_width(M*N);
  localparam int unsigned DEPTH = M * N;

  logic [OW-1:0] off_q;
  logic [SW-1:0] seg_q;
  logic [CW-1:0] fill_q;
  logic          off_last;
  logic          seg_last;
  logic          fill_full;

  assign off_last  = (off_q == OW'(M - 1));
  assign seg_last  = (seg_q == SW'(N - 1));
  assign fill_full = (fill_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      seg_q  <= '0;
      fill_q <= '0;
    end else if (adv) begin
      if (off_last) begin
        off_q <= '0;
        seg_q <= seg_last ? '0 : seg_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
      if (!fill_full) begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign off_o  = off_q;
  assign seg_o  = seg_q;
  assign fill_o = fill_q;

  // R4: the position wraps to zero after the last word of the last bank
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && off_last && seg_last) |=> (off_q == '0 && seg_q == '0));

  // R4: offset and bank number stay inside their ranges
  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    (off_q < OW'(M)) && (32'(seg_q) < N));

  // R2: with no shift the position holds
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(off_q) && $stable(seg_q)));

  // R3: fill count never passes the buffer depth
  a_r3_fill_sat: assert property (@(posedge clk) disable iff (rst)
    32'(fill_q) <= DEPTH);

endmodule

// File: rtl/tapline_bank.sv
// One bank of the delay buffer: simple dual-port, read-old-data on a
// same-address write, read and write gated by the same enable.
module tapline_bank
  import tapline_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic                          we,
  input  logic [tl_idx_width(DEPTH)-1:0] addr,
  input  logic [W-1:0]                  wdata,
  output logic [W-1:0]                  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tapline_tapsel.sv
// Registers the bank number and per-tap validity at each shift, then
// routes bank k-behind-the-writer to tap k, forcing unfilled taps to zero.
module tapline_tapsel
  import tapline_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4,
  parameter int unsigned N = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic [tl_idx_width(N)-1:0]   seg,
  input  logic [tl_cnt_width(M*N)-1:0] fill,
  input  logic [N-1:0][W-1:0]          bank_q,
  output logic [N*W-1:0]               taps
);

  localparam int unsigned SW = tl_idx_width(N);
  localparam int unsigned CW = tl_cnt_width(M*N);

  logic [SW-1:0] seg_q;
  logic [N-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      vld_q <= '0;
    end else if (adv) begin
      seg_q <= seg;
      for (int k = 1; k <= N; k++) begin
        vld_q[k-1] <= (fill >= CW'(k * M));
      end
    end
  end

  for (genvar k = 1; k <= N; k++) begin : g_tap
    logic [SW-1:0] src;

    // bank index (seg_q - k) mod N
    always_comb begin
      if (32'(seg_q) >= k) begin
        src = seg_q - SW'(k);
      end else begin
        src = seg_q + SW'(N - k);
      end
    end

    assign taps[(k-1)*W +: W] = vld_q[k-1] ? bank_q[src] : '0;

    if (k > 1) begin : g_thermo
      // R3: a deeper tap is never filled before a shallower one
      a_r3_fill_order: assert property (@(posedge clk) disable iff (rst)
        vld_q[k-1] |-> vld_q[k-2]);
    end
  end

  // R2: taps hold across an edge without a shift
  a_r2_taps_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(adv) && !$past(rst)) |-> $stable(taps));

endmodule

// File: rtl/tapline_ram.sv
// Top: multi-tap delay line held in N RAM banks of M words each.
module tapline_ram
  import tapline_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned M = 4,
  parameter int unsigned N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic [W-1:0]   din,
  output logic [N*W-1:0] taps_o
);

  localparam int unsigned OW         = tl_idx_width(M);
  localparam int unsigned SW         = tl_idx_width(N);
  localparam int unsigned CW         = tl_cnt_width(M*N);
  localparam int unsigned STORE_BITS = W * M * N;

  if (STORE_BITS > TL_MAX_STORE_BITS) begin : g_store_limit
    $error("tapline_ram: W*M*N exceeds the storage limit");
  end

  logic                adv;
  logic [OW-1:0]       off;
  logic [SW-1:0]       seg;
  logic [CW-1:0]       fill;
  logic [N-1:0][W-1:0] bank_q;

  // reset wins over a shift request (R8)
  assign adv = shift_en & ~rst;

  tapline_ptr #(
    .M (M),
    .N (N)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .off_o  (off),
    .seg_o  (seg),
    .fill_o (fill)
  );

  for (genvar b = 0; b < N; b++) begin : g_bank
    tapline_bank #(
      .W     (W),
      .DEPTH (M)
    ) u_bank (
      .clk   (clk),
      .en    (adv),
      .we    (seg == SW'(b)),
      .addr  (off),
      .wdata (din),
      .rdata (bank_q[b])
    );
  end

  tapline_tapsel #(
    .W (W),
    .M (M),
    .N (N)
  ) u_sel (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .seg    (seg),
    .fill   (fill),
    .bank_q (bank_q),
    .taps   (taps_o)
  );

  // R3 / R6: the edge after a reset cycle leaves every tap at zero
  a_r6_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (taps_o == '0));

  // R8: a reset cycle never advances the fill count
  a_r8_reset_no_entry: assert property (@(posedge clk)
    $past(rst) |-> (fill == '0));

endmodule

// File: tb/tapline_ram_tb.sv
`timescale 1ns/1ps
module tapline_ram_tb;

  localparam int W = 8;
  localparam int M = 3;
  localparam int N = 5;
  localparam int HIST = 64;
  localparam int NVEC = 24;

  // {shift_en, sample}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h111, 9'h122, 9'h133, 9'h144, 9'h055, 9'h155,
    9'h166, 9'h066, 9'h067, 9'h177, 9'h188, 9'h199,
    9'h1A1, 9'h0FF, 9'h1B2, 9'h1C3, 9'h1D4, 9'h1E5,
    9'h1F6, 9'h007, 9'h107, 9'h118, 9'h129, 9'h13A
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           shift_en = 1'b0;
  logic [W-1:0]   din = '0;
  logic [N*W-1:0] taps_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] hist [HIST];
  int cnt = 0;

  always #2 clk = ~clk;

  tapline_ram #(.W(W), .M(M), .N(N)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (din),
    .taps_o   (taps_o)
  );

  function automatic logic [N*W-1:0] model_taps();
    logic [N*W-1:0] v = '0;
    for (int k = 1; k <= N; k++) begin
      if (cnt > k * M) v[(k-1)*W +: W] = hist[(cnt - 1 - k * M) % HIST];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: taps=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, take the rising edge, look at the next falling edge
  task automatic step(input logic en, input logic [W-1:0] d);
    shift_en = en;
    din = d;
    @(posedge clk);
    if (rst) cnt = 0;
    else if (en) begin
      hist[cnt % HIST] = d;
      cnt++;
    end
    @(negedge clk);
  endtask

  function automatic string tag_for(input logic en);
    if (!en) return "R2";
    if (cnt <= N * M) return "R3";
    if (cnt == N * M + 1) return "R5";
    return "R1";
  endfunction

  initial begin
    logic [N*W-1:0] prev;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R3", taps_o, '0);

    // table walk: fill, gaps, first full delay of tap N
    prev = taps_o;
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][8], VEC[i][7:0]);
      check(tag_for(VEC[i][8]), taps_o, model_taps());
      if (!VEC[i][8]) check("R2", taps_o, prev);
      prev = taps_o;
    end

    // long run with idle gaps across many wraps
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic en;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = lfsr[0] | lfsr[3];
      step(en, lfsr[15:8]);
      check(en ? "R4" : "R7", taps_o, model_taps());
      if (!en) check("R7", taps_o, prev);
      prev = taps_o;
    end

    // mid-stream reset
    rst = 1'b1;
    step(1'b0, 8'h00);
    check("R6", taps_o, '0);
    rst = 1'b0;
    for (int i = 0; i < M + 2; i++) begin
      step(1'b1, 8'(8'h40 + i));
      check("R6", taps_o, model_taps());
    end

    // reset with shift request held high: no sample enters
    rst = 1'b1;
    step(1'b1, 8'hEE);
    step(1'b1, 8'hDD);
    check("R8", taps_o, '0);
    rst = 1'b0;
    for (int i = 0; i < N * M + 3; i++) begin
      step(1'b1, 8'(8'h80 + 3 * i));
      check("R8", taps_o, model_taps());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule